// File: doc/BRIEF.md
# Branch Target and Static Prediction Unit

This unit sits between fetch and decode. For each branch word it receives, it works out the branch target address, whether the branch is statically predicted taken, the address fetch should go to next, and whether the link register must be written with the return address. A 2-bit mode input, supplied by the surrounding opcode decoder, selects one of four target forms. Two forms carry an immediate displacement of 24 or 14 bits. The other two take the target from the link register or from the count register. The unit does not evaluate the condition register or the count register. It does not decode opcodes. It is not a pipeline, and it does not fetch instructions.

Each request enters on a valid/ready stream and leaves on a second valid/ready stream, with exactly one register stage between them. The unit takes a new request whenever its output slot is empty, or when that slot is being drained in the same cycle. While `out_ready` is low, a pending result stays on the outputs unchanged, and the input side applies back-pressure by dropping `in_ready`.

Instruction bits are numbered big-endian: instruction bit k is vector index 31-k.

Top module: `bt_unit`

## Requirements
- R1: In mode 0 (long immediate), the displacement is `in_instr[25:2]`. It is shifted left by two and sign-extended to 32 bits.
- R2: In mode 1 (short conditional), the displacement is `in_instr[15:2]`. It is shifted left by two and sign-extended to 32 bits.
- R3: In modes 0 and 1, `in_instr[1]` selects how the target is formed. When it is 0, the target is `in_cia` plus the extended displacement, taken modulo 2^32. When it is 1, the target is the extended displacement alone.
- R4: Mode 2 takes the target from `in_lr` and mode 3 takes it from `in_ctr`, in both cases with bits [1:0] forced to zero. In these modes `in_instr[1]` has no effect.
- R5: `out_lr_we` equals `in_instr[0]` in every mode. `out_link` is always `in_cia + 4` modulo 2^32.
- R6: Mode 0 is always predicted taken. Any other mode is predicted taken when `in_instr[25]` and `in_instr[23]` are both 1, meaning the branch tests neither the condition nor the counter. Mode 1 is also predicted taken when its displacement is negative (`in_instr[15]` = 1). In every other case the branch is predicted not taken.
- R7: `out_next` equals `out_target` when the branch is predicted taken, and equals `out_link` otherwise.
- R8: After reset, `out_valid` is 0. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and every output field keep their values.
- R9: Every accepted request produces exactly one result, one cycle after acceptance at the earliest. Results leave in the order the requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high together with in_valid |
| in_instr | input | 32 | Branch instruction word |
| in_cia | input | 32 | Address of the branch |
| in_lr | input | 32 | Link register value |
| in_ctr | input | 32 | Count register value |
| in_mode | input | 2 | Target form: 0 long imm, 1 short imm, 2 link reg, 3 count reg |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_target | output | 32 | Branch target address |
| out_next | output | 32 | Predicted next fetch address |
| out_link | output | 32 | Sequential address (return address) |
| out_taken | output | 1 | Static prediction: taken |
| out_lr_we | output | 1 | Link register write request |

## Verification
The bench builds the unit with its default 32-bit address width, 24-bit long displacement and 14-bit short displacement, so the field positions are the ones given in the requirements. At this width the bench can reach the largest positive and negative displacement of each form. With a branch address just below 2^32, it can also reach the carries that wrap the sequential address and the relative target through zero. A stretch with `out_ready` driven from a pseudo-random sequence makes back-pressure and output holding occur often alongside all four modes.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int XLEN       = 32;
  localparam int IW         = 32;
  localparam int LONG_W     = 24;
  localparam int SHORT_W    = 14;
  localparam int DISP_LSB   = 2;
  localparam int AA_IDX     = 1;
  localparam int LK_IDX     = 0;
  localparam int NOCOND_IDX = 25;
  localparam int NOCTR_IDX  = 23;
  localparam int SEQ_STEP   = 4;

  typedef enum logic [1:0] {
    TM_LONG  = 2'd0,
    TM_SHORT = 2'd1,
    TM_LINK  = 2'd2,
    TM_COUNT = 2'd3
  } tgt_mode_e;

  typedef struct packed {
    logic [XLEN-1:0] target;
    logic [XLEN-1:0] next;
    logic [XLEN-1:0] link;
    logic            taken;
    logic            lr_we;
  } bt_result_t;
endpackage

// File: rtl/bt_disp_ext.sv
module bt_disp_ext #(
  parameter int IN_W    = 32,
  parameter int FIELD_W = 24,
  parameter int LSB     = 2,
  parameter int OUT_W   = 32
) (
  input  logic [IN_W-1:0]  instr,
  output logic [OUT_W-1:0] ext,
  output logic             negative
);
  localparam int MSB   = LSB + FIELD_W - 1;
  localparam int PAD_W = OUT_W - FIELD_W - 2;

  logic [FIELD_W-1:0] field;

  assign field    = instr[MSB:LSB];
  assign negative = field[FIELD_W-1];

  generate
    if (PAD_W > 0) begin : g_pad
      assign ext = {{PAD_W{field[FIELD_W-1]}}, field, 2'b00};
    end else begin : g_nopad
      assign ext = {field[OUT_W-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/bt_target_sel.sv
module bt_target_sel
  import bt_pkg::*;
#(
  parameter int W = XLEN
) (
  input  tgt_mode_e       mode,
  input  logic            absolute,
  input  logic [W-1:0]    ext_long,
  input  logic [W-1:0]    ext_short,
  input  logic [W-1:0]    cia,
  input  logic [W-1:0]    lr,
  input  logic [W-1:0]    ctr,
  output logic [W-1:0]    target
);
  logic [W-1:0] disp;
  logic [W-1:0] imm_tgt;
  logic [W-1:0] reg_src;

  always_comb begin
    disp    = (mode == TM_LONG) ? ext_long : ext_short;
    imm_tgt = absolute ? disp : (cia + disp);
    reg_src = (mode == TM_LINK) ? lr : ctr;
    if (mode == TM_LONG || mode == TM_SHORT) target = imm_tgt;
    else target = {reg_src[W-1:2], 2'b00};
  end
endmodule

// File: rtl/bt_predict.sv
module bt_predict
  import bt_pkg::*;
(
  input  tgt_mode_e mode,
  input  logic      no_cond,
  input  logic      no_ctr,
  input  logic      short_neg,
  output logic      taken
);
  logic always_br;

  always_comb begin
    always_br = no_cond & no_ctr;
    unique case (mode)
      TM_LONG:  taken = 1'b1;
      TM_SHORT: taken = always_br | short_neg;
      default:  taken = always_br;
    endcase
  end
endmodule

// File: rtl/bt_out_stage.sv
module bt_out_stage
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  bt_result_t in_data,
  output logic       out_valid,
  input  logic       out_ready,
  output bt_result_t out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid); // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data)); // R8
  AST_NEXT_NT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_data.taken |-> out_data.next == out_data.link); // R7
  AST_NEXT_T: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_data.taken |-> out_data.next == out_data.target); // R7
endmodule

// File: rtl/bt_unit.sv
module bt_unit
  import bt_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [IW-1:0] in_instr,
  input  logic [W-1:0] in_cia,
  input  logic [W-1:0] in_lr,
  input  logic [W-1:0] in_ctr,
  input  logic [1:0]   in_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_target,
  output logic [W-1:0] out_next,
  output logic [W-1:0] out_link,
  output logic         out_taken,
  output logic         out_lr_we
);
  tgt_mode_e  mode;
  logic [W-1:0] ext_long, ext_short, target, seq;
  logic       long_neg, short_neg, taken;
  bt_result_t res_d, res_q;

  assign mode = tgt_mode_e'(in_mode);
  assign seq  = in_cia + W'(SEQ_STEP);

  bt_disp_ext #(.IN_W(IW), .FIELD_W(LONG_W), .LSB(DISP_LSB), .OUT_W(W)) i_ext_long (
    .instr(in_instr), .ext(ext_long), .negative(long_neg));

  bt_disp_ext #(.IN_W(IW), .FIELD_W(SHORT_W), .LSB(DISP_LSB), .OUT_W(W)) i_ext_short (
    .instr(in_instr), .ext(ext_short), .negative(short_neg));

  bt_target_sel #(.W(W)) i_tsel (
    .mode(mode), .absolute(in_instr[AA_IDX]), .ext_long(ext_long), .ext_short(ext_short),
    .cia(in_cia), .lr(in_lr), .ctr(in_ctr), .target(target));

  bt_predict i_pred (
    .mode(mode), .no_cond(in_instr[NOCOND_IDX]), .no_ctr(in_instr[NOCTR_IDX]),
    .short_neg(short_neg), .taken(taken));

  always_comb begin
    res_d.target = target;
    res_d.link   = seq;
    res_d.taken  = taken;
    res_d.next   = taken ? target : seq;
    res_d.lr_we  = in_instr[LK_IDX];
  end

  bt_out_stage i_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(res_d),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(res_q));

  assign out_target = res_q.target;
  assign out_next   = res_q.next;
  assign out_link   = res_q.link;
  assign out_taken  = res_q.taken;
  assign out_lr_we  = res_q.lr_we;

  logic in_fire;
  assign in_fire = in_valid && in_ready;

  AST_LINK_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid && out_link == W'($past(in_cia) + W'(SEQ_STEP))); // R5
  AST_LINK_WE: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_lr_we == $past(in_instr[LK_IDX])); // R5
  AST_LONG_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_mode == TM_LONG |=> out_taken); // R6
  AST_REG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_mode[1] |=> out_target[1:0] == 2'b00); // R4
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
endmodule

// File: tb/test_bt_unit.sv
`timescale 1ns/1ps
module test_bt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0, in_cia = '0, in_lr = '0, in_ctr = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_target, out_next, out_link;
  logic        out_taken, out_lr_we;

  always #2.5 clk = ~clk;

  bt_unit i_bt_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .in_cia(in_cia), .in_lr(in_lr), .in_ctr(in_ctr), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_target(out_target),
    .out_next(out_next), .out_link(out_link), .out_taken(out_taken), .out_lr_we(out_lr_we));

  typedef struct packed {
    logic [31:0] tgt, nxt, lnk;
    logic        tk, we;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0, n_fail = 0;
  logic rand_ready = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2357;
  bit   done = 1'b0;

  function automatic exp_t model(logic [1:0] mode, logic [31:0] i, logic [31:0] cia,
                                 logic [31:0] lr, logic [31:0] ctr);
    exp_t e;
    logic [31:0] d;
    logic always_br;
    always_br = i[25] && i[23];
    e.lnk = cia + 32'd4;                                        // R5
    e.we  = i[0];                                               // R5
    case (mode)
      2'd0: begin d = {{6{i[25]}}, i[25:2], 2'b00};             // R1
              e.tgt = i[1] ? d : cia + d; e.tk = 1'b1; end       // R3 R6
      2'd1: begin d = {{16{i[15]}}, i[15:2], 2'b00};            // R2
              e.tgt = i[1] ? d : cia + d; e.tk = always_br || i[15]; end
      2'd2: begin e.tgt = {lr[31:2], 2'b00}; e.tk = always_br; end   // R4
      default: begin e.tgt = {ctr[31:2], 2'b00}; e.tk = always_br; end
    endcase
    e.nxt = e.tk ? e.tgt : e.lnk;                               // R7
    return e;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic send(logic [1:0] mode, logic [31:0] i, logic [31:0] cia,
                      logic [31:0] lr, logic [31:0] ctr);
    @(negedge clk);
    in_valid = 1'b1; in_mode = mode; in_instr = i; in_cia = cia; in_lr = lr; in_ctr = ctr;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    exp_q.push_back(model(mode, i, cia, lr, ctr));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // instruction builders, big-endian bit k at index 31-k
  function automatic logic [31:0] mk_long(logic [23:0] d, logic aa, logic lk);
    return {6'd18, d, aa, lk};
  endfunction
  function automatic logic [31:0] mk_cond(logic [4:0] bo, logic [13:0] d, logic aa, logic lk);
    return {6'd16, bo, 5'd3, d, aa, lk};
  endfunction

  // ready driver
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      out_ready = rand_ready ? lfsr[3] : 1'b1;
    end
  end

  // monitor / scoreboard
  exp_t held;
  logic was_stalled = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (was_stalled) begin
          check("R8 valid held", {31'd0, out_valid}, 32'd1);
          check("R8 target held", out_target, held.tgt);
          check("R8 next held", out_next, held.nxt);
        end
        was_stalled = 1'b0;
        if (out_valid) begin
          held = '{out_target, out_next, out_link, out_taken, out_lr_we};
          if (!out_ready) was_stalled = 1'b1;
          else if (exp_q.size() == 0) begin
            n_tests++; n_fail++;
            $display("FAIL R9 result with no request actual=%h expected=none", out_target);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check("R1/R2/R3/R4 target", out_target, e.tgt);
            check("R7 next", out_next, e.nxt);
            check("R5 link", out_link, e.lnk);
            check("R6 taken", {31'd0, out_taken}, {31'd0, e.tk});
            check("R5 lr_we", {31'd0, out_lr_we}, {31'd0, e.we});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R8 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    // R1 long displacement extremes, relative and absolute (R3)
    send(2'd0, mk_long(24'h7FFFFF, 1'b0, 1'b0), 32'h0000_1000, 0, 0);
    send(2'd0, mk_long(24'h800000, 1'b0, 1'b1), 32'h0000_1000, 0, 0);
    send(2'd0, mk_long(24'h800000, 1'b1, 1'b0), 32'h1234_5678, 0, 0);
    send(2'd0, mk_long(24'h7FFFFF, 1'b1, 1'b1), 32'h1234_5678, 0, 0);
    // R3/R5 wraparound at 2^32
    send(2'd0, mk_long(24'h000010, 1'b0, 1'b1), 32'hFFFF_FFFC, 0, 0);
    // R2 short extremes, prediction by sign (R6)
    send(2'd1, mk_cond(5'b00100, 14'h1FFF, 1'b0, 1'b0), 32'h0000_8000, 0, 0);
    send(2'd1, mk_cond(5'b00100, 14'h2000, 1'b0, 1'b1), 32'h0000_8000, 0, 0);
    send(2'd1, mk_cond(5'b01100, 14'h2000, 1'b1, 1'b0), 32'h0000_8000, 0, 0);
    send(2'd1, mk_cond(5'b10100, 14'h0004, 1'b0, 1'b0), 32'hFFFF_FFF0, 0, 0);
    send(2'd1, mk_cond(5'b10000, 14'h0004, 1'b1, 1'b0), 32'hFFFF_FFF0, 0, 0);
    // R4 register forms, aa ignored
    send(2'd2, mk_cond(5'b10100, 14'h0, 1'b1, 1'b1), 32'h100, 32'hDEAD_BEEF, 32'h5);
    send(2'd2, mk_cond(5'b00100, 14'h0, 1'b0, 1'b0), 32'h100, 32'hDEAD_BEEF, 32'h5);
    send(2'd3, mk_cond(5'b10100, 14'h0, 1'b1, 1'b0), 32'h100, 32'h7, 32'hCAFE_F00D);
    send(2'd3, mk_cond(5'b00000, 14'h0, 1'b0, 1'b1), 32'hFFFF_FFFC, 32'h7, 32'hCAFE_F00D);
    // R8/R9 under random back-pressure
    rand_ready = 1'b1;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      a = $urandom(); b = $urandom();
      send(a[1:0], b, {a[31:2], 2'b00}, $urandom(), $urandom());
    end
    rand_ready = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 all results delivered", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule